// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller Pair

This block gathers sixteen interrupt lines into one request to a processor. There are two eight-input controller units. The primary unit talks to the processor. The secondary unit's request output is joined to one input of the primary unit, the cascade line, so its lines pass through the primary. A byte-wide bus with a small address map reaches each unit's command port and data port, and also a per-line trigger-mode register.

Software brings each unit up with a short write sequence. After that it uses the data port as an interrupt mask. The command port takes end-of-service commands and selects what the command port returns on a read. Each unit latches requests, masks them, and ranks them by fixed priority, with input 0 highest. It tracks which levels are being served and hands out a vector when the processor acknowledges. An acknowledge that the primary resolves to the cascade line is passed on to the secondary, and the secondary then supplies the vector.

Top module: `pic_cascade_pair`

## Requirements
- R1: After reset, every mask bit is 1, `int_out`, `vec_valid` and `bus_rdata` are 0, and a unit presents no interrupt until its setup sequence has completed.
- R2: A command-port write with bit 4 set starts setup and clears that unit's request and in-service bits. It sets the read selection to requests. Its bit 0 means a mode byte follows, its bit 1 means there is no cascade byte, and its bit 3 makes every input of that unit level-sensitive.
- R3: After a setup start, data-port writes are taken in this order: the vector base, then the cascade byte (unless skipped), then the mode byte (only if announced). Every later data-port write loads the mask, and data-port reads return the mask. A mask bit of 1 blocks its input.
- R4: An edge-sensitive input sets its request bit on a rising edge. The request bit is cleared when that request is acknowledged.
- R5: A level-sensitive input's request bit follows the input every cycle. This includes the cycle after it is acknowledged.
- R6: Priority is fixed, with input 0 highest. An unmasked request is presented only when its index is below the index of every in-service bit. `int_out` is the registered presented state of the primary unit.
- R7: A one-cycle `inta` pulse moves the presented request into service. In the next cycle `vec_valid` is 1 and `vec_out` equals the vector base plus the input index.
- R8: An acknowledge with nothing presented returns the vector base plus 7 and changes no state.
- R9: A command-port write with bit 4 and bit 3 clear is an end-of-service command. Value 0x20 clears the highest-priority in-service bit. Value 0x60 plus n clears in-service bit n. Any other such value is ignored.
- R10: A command-port write with bit 4 clear and bit 3 set is a read-select command. Low bits 3 select the in-service register for command-port reads, low bits 2 select the request register, and low bits 0 or 1 leave the selection unchanged.
- R11: The secondary request is ORed into primary input `CAS_LINE` (2). The acknowledge goes to the secondary when the primary's winning input has its bit set in the primary cascade byte and the secondary cascade byte equals that input number. The vector then comes from the secondary.
- R12: The trigger-mode register (1 = level) is at address 4 for lines 0-7 and address 5 for lines 8-15. Lines 0, 1, 2, 8 and 13 always read 0 and stay edge-sensitive.
- R13: The address map is 0/1 for the primary command/data ports, 2/3 for the secondary command/data ports, 4/5 for trigger mode, and 6/7 read 0. `bus_rdata` loads one cycle after `bus_rd` and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_in | input | 16 | Interrupt lines; 0-7 primary, 8-15 secondary |
| int_out | output | 1 | Registered interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse from the processor |
| vec_out | output | 8 | Vector delivered for the last acknowledge |
| vec_valid | output | 1 | `vec_out` is valid this cycle |

## Verification
The bench builds the block with its defaults: eight inputs per unit, cascade on primary input 2, and edge-only lines 0x2107. This brings a complete two-level path within reach, from a secondary line through the cascade line to a forwarded acknowledge. Under these defaults a vector base of 0x20 gives known vectors for every input and for a spurious acknowledge. They also let the fixed edge-only bits be observed on both bytes of the trigger register.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    INIT_IDLE,
    INIT_BASE,
    INIT_CASC,
    INIT_MODE,
    INIT_RUN
  } init_st_t;

  localparam int CMD_START_BIT = 4;
  localparam int CMD_SEL_BIT   = 3;
  localparam logic [2:0] EOS_TOP  = 3'b001;
  localparam logic [2:0] EOS_PICK = 3'b011;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pic_trig_reg.sv
module pic_trig_reg #(
  parameter int NT = 16,
  parameter int DW = 8,
  parameter logic [NT-1:0] FIXED_EDGE = 16'h2107,
  localparam int NB = NT / DW,
  localparam int SW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [SW-1:0] sel,
  input  logic [DW-1:0] wdata,
  output logic [NT-1:0] trig
);
  logic [NT-1:0] trig_nxt;

  always_comb begin
    trig_nxt = trig;
    for (int b = 0; b < NB; b++) begin
      if (wr && (sel == SW'(b))) trig_nxt[b*DW +: DW] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trig <= '0;
    else     trig <= trig_nxt & ~FIXED_EDGE;
  end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int DW   = 8,
  localparam int IW  = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_ctl,
  input  logic            wr_aux,
  input  logic [DW-1:0]   wdata,
  input  logic [N_IN-1:0] irq,
  input  logic [N_IN-1:0] trig,
  input  logic            ack,
  output logic            present,
  output logic [IW-1:0]   win,
  output logic [DW-1:0]   base,
  output logic [DW-1:0]   cas_cfg,
  output logic [DW-1:0]   ctl_rdata,
  output logic [DW-1:0]   aux_rdata
);
  init_st_t        st;
  logic [N_IN-1:0] imr, irr, isr, irq_q;
  logic [N_IN-1:0] irr_nxt, isr_nxt, rise;
  logic            need_mode, no_casc, all_level, rd_isr;
  logic            is_start, is_eos, is_sel, eos_top, eos_pick, take;
  logic            pend_hit, serv_hit;
  logic [IW-1:0]   pend_idx, serv_idx;

  assign is_start = wr_ctl && wdata[CMD_START_BIT];
  assign is_eos   = wr_ctl && !wdata[CMD_START_BIT] && !wdata[CMD_SEL_BIT];
  assign is_sel   = wr_ctl && !wdata[CMD_START_BIT] &&  wdata[CMD_SEL_BIT];
  assign eos_top  = is_eos && (wdata[7:5] == EOS_TOP);
  assign eos_pick = is_eos && (wdata[7:5] == EOS_PICK);

  pic_prio #(.N(N_IN)) u_pend (.req(irr & ~imr), .hit(pend_hit), .idx(pend_idx));
  pic_prio #(.N(N_IN)) u_serv (.req(isr),        .hit(serv_hit), .idx(serv_idx));

  assign present = (st == INIT_RUN) && pend_hit && (!serv_hit || (pend_idx < serv_idx));
  assign win     = pend_idx;
  assign take    = ack && present;
  assign rise    = irq & ~irq_q;

  genvar g;
  generate
    for (g = 0; g < N_IN; g++) begin : g_req
      logic lvl;
      assign lvl = all_level || trig[g];
      assign irr_nxt[g] = is_start ? 1'b0 :
                          lvl      ? irq[g] :
                          ((irr[g] && !(take && (win == IW'(g)))) || rise[g]);
    end
  endgenerate

  always_comb begin
    isr_nxt = isr;
    if (eos_top && serv_hit) isr_nxt[serv_idx] = 1'b0;
    if (eos_pick)            isr_nxt[wdata[IW-1:0]] = 1'b0;
    if (take)                isr_nxt[win] = 1'b1;
    if (is_start)            isr_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr   <= '0;
      isr   <= '0;
      irq_q <= '0;
    end else begin
      irr   <= irr_nxt;
      isr   <= isr_nxt;
      irq_q <= irq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= INIT_IDLE;
      imr       <= '1;
      base      <= '0;
      cas_cfg   <= '0;
      need_mode <= 1'b0;
      no_casc   <= 1'b0;
      all_level <= 1'b0;
      rd_isr    <= 1'b0;
    end else if (is_start) begin
      st        <= INIT_BASE;
      need_mode <= wdata[0];
      no_casc   <= wdata[1];
      all_level <= wdata[3];
      rd_isr    <= 1'b0;
    end else begin
      if (wr_aux) begin
        case (st)
          INIT_BASE: begin
            base <= wdata;
            st   <= no_casc ? (need_mode ? INIT_MODE : INIT_RUN) : INIT_CASC;
          end
          INIT_CASC: begin
            cas_cfg <= wdata;
            st      <= need_mode ? INIT_MODE : INIT_RUN;
          end
          INIT_MODE: st <= INIT_RUN;
          default:   imr <= wdata[N_IN-1:0];
        endcase
      end
      if (is_sel && wdata[1]) rd_isr <= wdata[0];
    end
  end

  assign ctl_rdata = DW'(rd_isr ? isr : irr);
  assign aux_rdata = DW'(imr);
endmodule

// File: rtl/pic_cascade_pair.sv
module pic_cascade_pair
  import pic_pkg::*;
#(
  parameter int N_IN     = 8,
  parameter int DW       = 8,
  parameter int CAS_LINE = 2,
  parameter logic [2*N_IN-1:0] FIXED_EDGE = 16'h2107,
  localparam int NT = 2 * N_IN,
  localparam int IW = $clog2(N_IN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [15:0]   irq_in,
  output logic          int_out,
  input  logic          inta,
  output logic [7:0]    vec_out,
  output logic          vec_valid
);
  logic [NT-1:0]   trig_q;
  logic [N_IN-1:0] cas_hook, m_irq;
  logic            m_present, s_present, fwd, s_ack;
  logic [IW-1:0]   m_win, s_win, m_sel, s_sel;
  logic [DW-1:0]   m_base, s_base, m_cas, s_cas;
  logic [DW-1:0]   m_ctl, m_aux, s_ctl, s_aux, vec_nxt;

  pic_trig_reg #(.NT(NT), .DW(DW), .FIXED_EDGE(FIXED_EDGE)) u_trig (
    .clk(clk), .rst(rst),
    .wr(bus_wr && (bus_addr[2:1] == 2'b10)),
    .sel(bus_addr[0]),
    .wdata(bus_wdata),
    .trig(trig_q)
  );

  always_comb begin
    cas_hook           = '0;
    cas_hook[CAS_LINE] = s_present;
  end
  assign m_irq = irq_in[N_IN-1:0] | cas_hook;

  pic_unit #(.N_IN(N_IN), .DW(DW)) u_prim (
    .clk(clk), .rst(rst),
    .wr_ctl(bus_wr && (bus_addr == 3'd0)),
    .wr_aux(bus_wr && (bus_addr == 3'd1)),
    .wdata(bus_wdata), .irq(m_irq), .trig(trig_q[N_IN-1:0]), .ack(inta),
    .present(m_present), .win(m_win), .base(m_base), .cas_cfg(m_cas),
    .ctl_rdata(m_ctl), .aux_rdata(m_aux)
  );

  assign fwd   = m_present && m_cas[m_win] && (s_cas == DW'(m_win));
  assign s_ack = inta && fwd;

  pic_unit #(.N_IN(N_IN), .DW(DW)) u_sec (
    .clk(clk), .rst(rst),
    .wr_ctl(bus_wr && (bus_addr == 3'd2)),
    .wr_aux(bus_wr && (bus_addr == 3'd3)),
    .wdata(bus_wdata), .irq(irq_in[NT-1:N_IN]), .trig(trig_q[NT-1:N_IN]), .ack(s_ack),
    .present(s_present), .win(s_win), .base(s_base), .cas_cfg(s_cas),
    .ctl_rdata(s_ctl), .aux_rdata(s_aux)
  );

  assign m_sel   = m_present ? m_win : IW'(N_IN - 1);
  assign s_sel   = s_present ? s_win : IW'(N_IN - 1);
  assign vec_nxt = fwd ? (s_base + DW'(s_sel)) : (m_base + DW'(m_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      int_out   <= 1'b0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      bus_rdata <= '0;
    end else begin
      int_out   <= m_present;
      vec_valid <= inta;
      if (inta) vec_out <= vec_nxt;
      if (bus_rd) begin
        case (bus_addr)
          3'd0:    bus_rdata <= m_ctl;
          3'd1:    bus_rdata <= m_aux;
          3'd2:    bus_rdata <= s_ctl;
          3'd3:    bus_rdata <= s_aux;
          3'd4:    bus_rdata <= trig_q[DW-1:0];
          3'd5:    bus_rdata <= trig_q[NT-1:DW];
          default: bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_cascade_pair_chk.sv
module pic_cascade_pair_chk #(
  parameter int NT = 16,
  parameter logic [NT-1:0] FIXED_EDGE = 16'h2107
) (
  input logic          clk,
  input logic          rst,
  input logic          inta,
  input logic          vec_valid,
  input logic          bus_rd,
  input logic [7:0]    bus_rdata,
  input logic [NT-1:0] trig_q
);
  AST_EDGE_ONLY_LINES: assert property (@(posedge clk) disable iff (rst)
    (trig_q & FIXED_EDGE) == '0); // R12
  AST_ACK_YIELDS_VECTOR: assert property (@(posedge clk) disable iff (rst)
    inta |=> vec_valid); // R7
  AST_VECTOR_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(inta)); // R7
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R13
endmodule

bind pic_cascade_pair pic_cascade_pair_chk #(.NT(NT), .FIXED_EDGE(FIXED_EDGE)) i_chk (
  .clk(clk), .rst(rst), .inta(inta), .vec_valid(vec_valid),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .trig_q(trig_q)
);

// File: tb/test_pic_cascade_pair.sv
`timescale 1ns/1ps
module test_pic_cascade_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, inta = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] irq_in = '0;
  logic [7:0]  bus_rdata, vec_out;
  logic        int_out, vec_valid;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pic_cascade_pair i_pic_cascade_pair (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .int_out(int_out), .inta(inta), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  // {write, addr, data, expected read}
  localparam int NSTEP = 27;
  localparam logic [19:0] STEPS [0:NSTEP-1] = '{
    {1'b1, 3'd0, 8'h11, 8'h00}, {1'b1, 3'd1, 8'h20, 8'h00},
    {1'b1, 3'd1, 8'h04, 8'h00}, {1'b1, 3'd1, 8'h01, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h00},
    {1'b1, 3'd2, 8'h11, 8'h00}, {1'b1, 3'd3, 8'h28, 8'h00},
    {1'b1, 3'd3, 8'h02, 8'h00}, {1'b1, 3'd3, 8'h01, 8'h00},
    {1'b1, 3'd3, 8'h00, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd3, 8'h00, 8'h00},
    {1'b1, 3'd1, 8'h5A, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h5A},
    {1'b1, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b1, 3'd0, 8'h0B, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b1, 3'd4, 8'hFF, 8'h00}, {1'b0, 3'd4, 8'h00, 8'hF8},
    {1'b1, 3'd5, 8'hFF, 8'h00}, {1'b0, 3'd5, 8'h00, 8'hDE},
    {1'b0, 3'd6, 8'h00, 8'h00}, {1'b0, 3'd7, 8'h00, 8'h00},
    {1'b1, 3'd4, 8'h00, 8'h00}, {1'b1, 3'd5, 8'h00, 8'h00},
    {1'b0, 3'd4, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_bus(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] e);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, e);
  endtask

  task automatic ack_chk(input string req, input logic [7:0] e);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    check({req, " valid"}, {7'd0, vec_valid}, 8'h01);
    check({req, " vector"}, vec_out, e);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1 int_out", {7'd0, int_out}, 8'h00);
    check("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rd_chk("R1 primary mask", 3'd1, 8'hFF);
    rd_chk("R1 secondary mask", 3'd3, 8'hFF);
    irq_in[5] = 1'b1; tick(5);
    check("R1 no int before setup", {7'd0, int_out}, 8'h00);
    irq_in[5] = 1'b0; tick(2);

    // Table: setup (R3), readback (R10, R12, R13)
    for (int i = 0; i < NSTEP; i++) begin
      if (STEPS[i][19]) wr_bus(STEPS[i][18:16], STEPS[i][15:8]);
      else rd_chk("R3/R12/R13 table", STEPS[i][18:16], STEPS[i][7:0]);
    end
    tick(3);
    check("R13 rdata held", bus_rdata, 8'h00);

    // R4 edge request, R7 acknowledge
    irq_in[5] = 1'b1; tick(4);
    check("R4 int on edge", {7'd0, int_out}, 8'h01);
    ack_chk("R7", 8'h25);
    tick(2);
    check("R6 int off while served", {7'd0, int_out}, 8'h00);
    rd_chk("R7 in-service", 3'd0, 8'h20);
    wr_bus(3'd0, 8'h0A);
    rd_chk("R4 request cleared", 3'd0, 8'h00);
    wr_bus(3'd0, 8'h0B);

    // R6 nesting, R9 end-of-service
    irq_in[6] = 1'b1; tick(4);
    check("R6 lower blocked", {7'd0, int_out}, 8'h00);
    irq_in[3] = 1'b1; tick(4);
    check("R6 higher presented", {7'd0, int_out}, 8'h01);
    ack_chk("R6", 8'h23);
    rd_chk("R6 nested service", 3'd0, 8'h28);
    wr_bus(3'd0, 8'h20);
    rd_chk("R9 clear top", 3'd0, 8'h20);
    wr_bus(3'd0, 8'h40);
    rd_chk("R9 other ignored", 3'd0, 8'h20);
    wr_bus(3'd0, 8'h65);
    rd_chk("R9 clear picked", 3'd0, 8'h00);
    tick(3);
    ack_chk("R6 pending lower", 8'h26);
    wr_bus(3'd0, 8'h20);
    irq_in[3] = 1'b0; irq_in[5] = 1'b0; irq_in[6] = 1'b0;
    tick(3);

    // R8 spurious
    check("R8 idle", {7'd0, int_out}, 8'h00);
    ack_chk("R8", 8'h27);
    rd_chk("R8 no service change", 3'd0, 8'h00);

    // R5 level via trigger register
    wr_bus(3'd4, 8'h10);
    irq_in[4] = 1'b1; tick(4);
    ack_chk("R5", 8'h24);
    wr_bus(3'd0, 8'h0A);
    rd_chk("R5 request kept", 3'd0, 8'h10);
    irq_in[4] = 1'b0; tick(2);
    rd_chk("R5 request follows", 3'd0, 8'h00);
    wr_bus(3'd0, 8'h20);
    wr_bus(3'd4, 8'h00);

    // R2 restart with cascade byte skipped
    irq_in[7] = 1'b1; tick(4);
    ack_chk("R2 pre", 8'h27);
    wr_bus(3'd0, 8'h13);
    wr_bus(3'd1, 8'h20);
    wr_bus(3'd1, 8'h01);
    wr_bus(3'd1, 8'h11);
    rd_chk("R2/R3 mask after short setup", 3'd1, 8'h11);
    wr_bus(3'd0, 8'h0B);
    rd_chk("R2 service cleared", 3'd0, 8'h00);
    wr_bus(3'd1, 8'h00);
    irq_in[7] = 1'b0; tick(2);

    // R11 cascade
    irq_in[10] = 1'b1; tick(6);
    check("R11 int via cascade", {7'd0, int_out}, 8'h01);
    ack_chk("R11", 8'h2A);
    rd_chk("R11 primary service", 3'd0, 8'h04);
    wr_bus(3'd2, 8'h0B);
    rd_chk("R11 secondary service", 3'd2, 8'h04);
    wr_bus(3'd2, 8'h09);
    rd_chk("R10 select kept", 3'd2, 8'h04);
    wr_bus(3'd2, 8'h20);
    wr_bus(3'd0, 8'h20);
    irq_in[10] = 1'b0; tick(2);

    // R3/R11 masked cascade line
    wr_bus(3'd1, 8'h04);
    irq_in[12] = 1'b1; tick(6);
    check("R3 cascade masked", {7'd0, int_out}, 8'h00);
    wr_bus(3'd1, 8'h00); tick(3);
    check("R11 unmasked", {7'd0, int_out}, 8'h01);
    ack_chk("R11 second", 8'h2C);
    wr_bus(3'd2, 8'h20);
    wr_bus(3'd0, 8'h20);
    irq_in[12] = 1'b0; tick(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule